// File: doc/BRIEF.md
# Byte-Swapping ALU Operand Path

This block is the 16-bit slice between a memory data register and the arithmetic unit. A row of two-input multiplexers either exchanges the two bytes of a word or passes it through unchanged, under a control line. One such stage sits on the way into the arithmetic unit and another on the way back out. Byte operations therefore need no separate shifter and no extra clock cycle. A byte-swap instruction is an ordinary move with the inbound exchange turned on.

Each cycle the block takes two operands: source A and destination B. It also takes an operation code, a byte-mode flag, the low address bit and the two swap enables. One rising edge later it presents the value to write back, a write strobe, and five status bits: logical-greater, arithmetic-greater, equal, carry and overflow. In byte mode the addressed byte is moved to the most significant lane and operated on alone. The untouched byte of the destination is merged back before the outbound stage restores the lane order. Memory timing, microcode sequencing and multi-cycle multiply/divide live outside this block.

Top module: `byte_swap_alu_path`

## Requirements
- R1: A synchronous active-low reset clears `result_o`, `wr_o` and all five status outputs to 0 at the next rising edge.
- R2: Every output is registered. The outputs present the result of the inputs sampled at the previous rising edge, one operation per cycle, whether or not swaps are in use.
- R3: Two-operand codes on `op_i` are 4'b0111 B OR A, 4'b0110 move A, 4'b0101 B + A, 4'b0011 A − B, 4'b0010 B AND NOT A, and 4'b0100 compare (A − B, status only). Each of these except compare raises `wr_o`.
- R4: Single-operand codes on `op_i` act on B and raise `wr_o`: 4'b1000 negate (−B), 4'b1001 invert (NOT B), 4'b1010 all ones.
- R5: The inbound stage swaps both operands' bytes when `swap_in_i` is 1, or when `byte_i` and `addr_lo_i` are both 1. The outbound stage swaps the result when `swap_out_i` is 1, or when `byte_i` and `addr_lo_i` are both 1. A move with only `swap_in_i` set returns A with its bytes exchanged. A move with both enables set returns A unchanged.
- R6: In byte mode, `addr_lo_i`=0 selects the most significant byte (bits 15:8) and `addr_lo_i`=1 selects the least significant byte (bits 7:0). Only the selected byte is computed. The other byte of `result_o` equals the same byte of B.
- R7: For compare, `eq_o` = (A == B), `lgt_o` = (A > B unsigned) and `agt_o` = (A > B signed). For every other code, `eq_o` = (result == 0), `lgt_o` = (result != 0) and `agt_o` = (result > 0 signed).
- R8: Carry is the carry out of the most significant bit. Subtract, compare and negate add the one's complement plus one, so carry means no borrow. Overflow is two's-complement overflow of that sum. Both are 0 for OR, move, AND NOT, invert and all ones.
- R9: In byte mode all five status bits are computed on the selected byte alone, with the sign taken from that byte's top bit.
- R10: Compare, and the unassigned codes (4'b0000, 4'b0001, 4'b1011 to 4'b1111), leave `wr_o` at 0 and drive B, unchanged in position, on `result_o`. The unassigned codes set status as for a result equal to B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 4 | Operation code |
| byte_i | input | 1 | Byte-mode select |
| addr_lo_i | input | 1 | Low address bit, picks the byte lane |
| swap_in_i | input | 1 | Force the inbound byte exchange |
| swap_out_i | input | 1 | Force the outbound byte exchange |
| a_i | input | 16 | Source operand A |
| b_i | input | 16 | Destination operand B |
| result_o | output | 16 | Value to write back |
| wr_o | output | 1 | Write-back strobe |
| lgt_o | output | 1 | Logical (unsigned) greater |
| agt_o | output | 1 | Arithmetic (signed) greater |
| eq_o | output | 1 | Equal / zero |
| cy_o | output | 1 | Carry out |
| ov_o | output | 1 | Signed overflow |

## Verification
The bench builds the block with its default 16-bit word, so each byte is 8 bits wide. This makes the byte-lane boundary values reachable with short literal vectors: 0x7F+1, 0xFF+1, 0x80 compared with 0x01, and negation of 0x8000 and of zero. With a 16-bit word the signed and unsigned orderings of a compare can disagree on a single vector, and a carry out of the low byte can be told apart from a carry out of the selected byte. Both lanes are driven, with each swap enable alone and with both together, so the merge of the untouched byte and the cancelling of two swaps show at the ports.

// File: rtl/alu_path_pkg.sv
// Package: shared operation codes and helpers for the byte-swapping ALU path.
// Assumes a 4-bit operation code; codes not listed here are unassigned.
package alu_path_pkg;

    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OP_ANDN = 4'b0010;
    localparam logic [OP_W-1:0] OP_SUB  = 4'b0011;
    localparam logic [OP_W-1:0] OP_CMP  = 4'b0100;
    localparam logic [OP_W-1:0] OP_ADD  = 4'b0101;
    localparam logic [OP_W-1:0] OP_MOV  = 4'b0110;
    localparam logic [OP_W-1:0] OP_OR   = 4'b0111;
    localparam logic [OP_W-1:0] OP_NEG  = 4'b1000;
    localparam logic [OP_W-1:0] OP_INV  = 4'b1001;
    localparam logic [OP_W-1:0] OP_ONES = 4'b1010;

    // Status bundle, most significant first: lgt, agt, eq, cy, ov.
    typedef struct packed {
        logic lgt;
        logic agt;
        logic eq;
        logic cy;
        logic ov;
    } status_t;

    // True for codes that write their result back.
    function automatic logic op_writes(input logic [OP_W-1:0] op);
        case (op)
            OP_OR, OP_MOV, OP_ADD, OP_SUB, OP_ANDN,
            OP_NEG, OP_INV, OP_ONES: op_writes = 1'b1;
            default:                 op_writes = 1'b0;
        endcase
    endfunction

    // True for codes whose carry and overflow are always cleared.
    function automatic logic op_is_logic(input logic [OP_W-1:0] op);
        case (op)
            OP_OR, OP_MOV, OP_ANDN, OP_INV, OP_ONES: op_is_logic = 1'b1;
            default:                                 op_is_logic = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/lane_swap.sv
// Module: lane_swap
// One bank of two-input multiplexers. When en is high, the upper and lower
// halves of the word trade places; when it is low, the word passes through.
// Assumes WIDTH is even. Purely combinational; adds no cycle.
module lane_swap #(
    parameter int WIDTH = 16
) (
    input  logic             en,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int HALF = WIDTH / 2;

    // One multiplexer per bit, each choosing its own bit or its mirror across the halves.
    for (genvar i = 0; i < WIDTH; i++) begin : g_mux
        localparam int SRC = (i + HALF) % WIDTH;
        assign q[i] = en ? d[SRC] : d[i];
    end
endmodule

// File: rtl/alu_core.sv
// Module: alu_core
// Word-wide operation unit. Operands arrive already lane-aligned. In byte
// mode the lower half of each operand is zero, so the carry and overflow of
// the top bit are those of the byte. Arithmetic codes share one adder fed
// with (x, y, cin).
module alu_core
    import alu_path_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [OP_W-1:0]  op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] r,
    output logic             cy,
    output logic             ov
);
    logic [WIDTH-1:0] x, y;
    logic             cin;
    logic [WIDTH:0]   sum;
    logic             arith;

    // Select the adder inputs for the arithmetic codes.
    always_comb begin
        x     = a;
        y     = b;
        cin   = 1'b0;
        arith = 1'b0;
        case (op)
            OP_ADD: begin x = a; y = b; cin = 1'b0; arith = 1'b1; end
            OP_SUB,
            OP_CMP: begin x = a; y = ~b; cin = 1'b1; arith = 1'b1; end
            OP_NEG: begin x = '0; y = ~b; cin = 1'b1; arith = 1'b1; end
            default: ;
        endcase
    end

    // Shared adder, one bit wider than the word for the carry.
    assign sum = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};

    // Pick the result per operation code; compare and unassigned codes pass B.
    always_comb begin
        case (op)
            OP_OR:   r = b | a;
            OP_MOV:  r = a;
            OP_ADD,
            OP_SUB,
            OP_NEG:  r = sum[WIDTH-1:0];
            OP_ANDN: r = b & ~a;
            OP_INV:  r = ~b;
            OP_ONES: r = '1;
            default: r = b;
        endcase
    end

    // Carry and overflow come from the adder only when it was used.
    always_comb begin
        cy = arith & sum[WIDTH];
        ov = arith & (x[WIDTH-1] == y[WIDTH-1]) & (sum[WIDTH-1] != x[WIDTH-1]);
    end
endmodule

// File: rtl/status_unit.sv
// Module: status_unit
// Derives equal and the two greater-than bits. A compare relates the
// operands to each other; every other code relates its result to zero.
// Assumes operands and result are already masked to the active lane.
module status_unit #(
    parameter int WIDTH = 16
) (
    input  logic             is_cmp,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [WIDTH-1:0] r,
    output logic             lgt,
    output logic             agt,
    output logic             eq
);
    // Choose between operand comparison and sign/zero tests of the result.
    always_comb begin
        if (is_cmp) begin
            eq  = (a == b);
            lgt = (a > b);
            agt = ($signed(a) > $signed(b));
        end else begin
            eq  = (r == '0);
            lgt = (r != '0);
            agt = !r[WIDTH-1] && (r != '0);
        end
    end
endmodule

// File: rtl/byte_swap_alu_path.sv
// Module: byte_swap_alu_path (top)
// Operand path from the memory data register through an inbound byte swap,
// the operation unit, a byte-lane merge and an outbound byte swap to one
// output register. One operation is taken per cycle; results appear one
// clock later. Assumes DATA_W is even; addr_lo_i = 0 names the upper byte.
module byte_swap_alu_path
    import alu_path_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_i,
    input  logic              byte_i,
    input  logic              addr_lo_i,
    input  logic              swap_in_i,
    input  logic              swap_out_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_o,
    output logic              lgt_o,
    output logic              agt_o,
    output logic              eq_o,
    output logic              cy_o,
    output logic              ov_o
);
    localparam int BYTE_W = DATA_W / 2;
    localparam logic [BYTE_W-1:0] ZERO_B = '0;

    logic              in_sw, out_sw;
    logic [DATA_W-1:0] a_sw, b_sw;
    logic [DATA_W-1:0] a_alu, b_alu;
    logic [DATA_W-1:0] r_raw, r_mask, r_pre, r_out;
    logic              alu_cy, alu_ov;
    status_t           st_d, st_q;

    // Swap controls: forced by the enables, or by an odd byte address.
    always_comb begin
        in_sw  = swap_in_i  | (byte_i & addr_lo_i);
        out_sw = swap_out_i | (byte_i & addr_lo_i);
    end

    lane_swap #(.WIDTH(DATA_W)) u_swap_a (.en(in_sw), .d(a_i), .q(a_sw));
    lane_swap #(.WIDTH(DATA_W)) u_swap_b (.en(in_sw), .d(b_i), .q(b_sw));

    // Byte mode keeps only the upper lane so the top bit carries the byte's sign.
    always_comb begin
        a_alu = byte_i ? {a_sw[DATA_W-1:BYTE_W], ZERO_B} : a_sw;
        b_alu = byte_i ? {b_sw[DATA_W-1:BYTE_W], ZERO_B} : b_sw;
    end

    alu_core #(.WIDTH(DATA_W)) u_alu (
        .op (op_i),
        .a  (a_alu),
        .b  (b_alu),
        .r  (r_raw),
        .cy (alu_cy),
        .ov (alu_ov)
    );

    // Mask the result for status, and merge B's untouched byte for write-back.
    always_comb begin
        r_mask = byte_i ? {r_raw[DATA_W-1:BYTE_W], ZERO_B} : r_raw;
        r_pre  = byte_i ? {r_raw[DATA_W-1:BYTE_W], b_sw[BYTE_W-1:0]} : r_raw;
    end

    lane_swap #(.WIDTH(DATA_W)) u_swap_out (.en(out_sw), .d(r_pre), .q(r_out));

    status_unit #(.WIDTH(DATA_W)) u_status (
        .is_cmp (op_i == OP_CMP),
        .a      (a_alu),
        .b      (b_alu),
        .r      (r_mask),
        .lgt    (st_d.lgt),
        .agt    (st_d.agt),
        .eq     (st_d.eq)
    );

    // Carry and overflow pass straight from the operation unit.
    always_comb begin
        st_d.cy = alu_cy;
        st_d.ov = alu_ov;
    end

    // Capture register: result, write strobe and status, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            wr_o     <= 1'b0;
            st_q     <= '0;
        end else begin
            result_o <= r_out;
            wr_o     <= op_writes(op_i);
            st_q     <= st_d;
        end
    end

    // Status outputs unpacked from the captured bundle.
    always_comb begin
        lgt_o = st_q.lgt;
        agt_o = st_q.agt;
        eq_o  = st_q.eq;
        cy_o  = st_q.cy;
        ov_o  = st_q.ov;
    end

    // A compare never raises the write strobe (R10).
    p_cmp_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CMP) |=> !wr_o);

    // Two swaps on a word move cancel out (R5).
    p_double_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_MOV && !byte_i && swap_in_i && swap_out_i)
        |=> (result_o == $past(a_i)));

    // Upper-lane byte operation leaves the lower byte of B in place (R6).
    p_keep_other_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_i && !addr_lo_i && !swap_in_i && !swap_out_i)
        |=> (result_o[BYTE_W-1:0] == $past(b_i[BYTE_W-1:0])));

    // Logic codes report neither carry nor overflow (R8).
    p_logic_no_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        op_is_logic(op_i) |=> (!cy_o && !ov_o));

    // Equal excludes both greater-than bits (R7).
    p_eq_excludes_gt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eq_o |-> (!lgt_o && !agt_o));

    // Set-all-ones on a word with no outbound swap writes all ones (R4).
    p_ones_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ONES && !byte_i) |=> (result_o == '1 && wr_o));
endmodule

// File: tb/tb_byte_swap_alu_path.sv
`timescale 1ns/1ps
// Bench for byte_swap_alu_path: a vector table walked once, then directed
// checks of reset and of the output register's timing.
module tb_byte_swap_alu_path;
    localparam int W = 16;
    // Vector layout: op(4) byte addr sin sout(4) a(16) b(16) res(16) wr(1) st(5)
    // st = {lgt, agt, eq, cy, ov}
    localparam int VW = 62;
    localparam int NV = 23;
    localparam logic [VW-1:0] VEC [NV] = '{
        {4'b0111, 4'b0000, 16'h00F0, 16'h0F00, 16'h0FF0, 1'b1, 5'b11000}, // R3 or
        {4'b0110, 4'b0000, 16'h8000, 16'h1234, 16'h8000, 1'b1, 5'b10000}, // R3 move
        {4'b0101, 4'b0000, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 5'b00110}, // R8 add carry
        {4'b0101, 4'b0000, 16'h7FFF, 16'h0001, 16'h8000, 1'b1, 5'b10001}, // R8 add ovf
        {4'b0100, 4'b0000, 16'h0005, 16'h0003, 16'h0003, 1'b0, 5'b11010}, // R7 cmp gt
        {4'b0100, 4'b0000, 16'hFFFF, 16'h0001, 16'h0001, 1'b0, 5'b10010}, // R7 cmp sign
        {4'b0100, 4'b0000, 16'h1234, 16'h1234, 16'h1234, 1'b0, 5'b00110}, // R7 cmp eq
        {4'b0011, 4'b0000, 16'h0003, 16'h0005, 16'hFFFE, 1'b1, 5'b10000}, // R3 sub
        {4'b0011, 4'b0000, 16'h8000, 16'h0001, 16'h7FFF, 1'b1, 5'b11011}, // R8 sub ovf
        {4'b0010, 4'b0000, 16'h00FF, 16'h1234, 16'h1200, 1'b1, 5'b11000}, // R3 and-not
        {4'b1000, 4'b0000, 16'h5555, 16'h0001, 16'hFFFF, 1'b1, 5'b10000}, // R4 neg
        {4'b1000, 4'b0000, 16'h5555, 16'h0000, 16'h0000, 1'b1, 5'b00110}, // R4 neg zero
        {4'b1000, 4'b0000, 16'h5555, 16'h8000, 16'h8000, 1'b1, 5'b10001}, // R4 neg min
        {4'b1001, 4'b0000, 16'h5555, 16'h0F0F, 16'hF0F0, 1'b1, 5'b10000}, // R4 invert
        {4'b1010, 4'b0000, 16'h1111, 16'h2222, 16'hFFFF, 1'b1, 5'b10000}, // R4 all ones
        {4'b0110, 4'b0010, 16'h1234, 16'h0000, 16'h3412, 1'b1, 5'b11000}, // R5 swap in
        {4'b0110, 4'b0001, 16'h1234, 16'h0000, 16'h3412, 1'b1, 5'b11000}, // R5 swap out
        {4'b0101, 4'b1000, 16'h7F11, 16'h0122, 16'h8022, 1'b1, 5'b10001}, // R6 R9 hi lane
        {4'b0101, 4'b1100, 16'h11FF, 16'h3301, 16'h3300, 1'b1, 5'b00110}, // R6 R9 lo lane
        {4'b0100, 4'b1100, 16'h0080, 16'h0001, 16'h0001, 1'b0, 5'b10011}, // R9 R10 byte cmp
        {4'b0011, 4'b1000, 16'h0500, 16'h03AA, 16'h02AA, 1'b1, 5'b11010}, // R6 byte sub
        {4'b1001, 4'b1100, 16'h0000, 16'h12F0, 16'h120F, 1'b1, 5'b11000}, // R6 byte inv
        {4'b0000, 4'b0000, 16'hFFFF, 16'h5A5A, 16'h5A5A, 1'b0, 5'b11000}  // R10 unassigned
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic [3:0]   op_i;
    logic         byte_i, addr_lo_i, swap_in_i, swap_out_i;
    logic [W-1:0] a_i, b_i;
    logic [W-1:0] result_o;
    logic         wr_o, lgt_o, agt_o, eq_o, cy_o, ov_o;
    int           checks = 0;
    int           errors = 0;
    bit           done = 1'b0;

    always #2.5 clk = ~clk;

    byte_swap_alu_path #(.DATA_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .byte_i(byte_i),
        .addr_lo_i(addr_lo_i), .swap_in_i(swap_in_i), .swap_out_i(swap_out_i),
        .a_i(a_i), .b_i(b_i), .result_o(result_o), .wr_o(wr_o),
        .lgt_o(lgt_o), .agt_o(agt_o), .eq_o(eq_o), .cy_o(cy_o), .ov_o(ov_o)
    );

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic drive(input logic [VW-1:0] v);
        {op_i, byte_i, addr_lo_i, swap_in_i, swap_out_i, a_i, b_i} = v[VW-1:22];
    endtask

    initial begin
        rst_n = 1'b0;
        drive({4'b0101, 4'b0000, 16'h7FFF, 16'h0001, 22'h0});
        repeat (3) @(negedge clk);
        // R1: reset state with active inputs
        check("R1 result", result_o, '0);
        check("R1 wr/status", {10'h0, wr_o, lgt_o, agt_o, eq_o, cy_o, ov_o}, '0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            // R2: each vector is checked one clock after it is applied
            check($sformatf("R3/R5/R6 result v%0d", i), result_o, VEC[i][21:6]);
            check($sformatf("R10 write v%0d", i), {15'h0, wr_o}, {15'h0, VEC[i][5]});
            check($sformatf("R7/R8/R9 status v%0d", i),
                  {11'h0, lgt_o, agt_o, eq_o, cy_o, ov_o}, {11'h0, VEC[i][4:0]});
        end

        // R2: a new input does not reach the outputs before the next edge
        drive({4'b0110, 4'b0000, 16'hABCD, 16'h0000, 22'h0});
        @(negedge clk);
        drive({4'b0110, 4'b0000, 16'h1111, 16'h0000, 22'h0});
        #1;
        check("R2 held until edge", result_o, 16'hABCD);
        @(negedge clk);
        check("R2 updated after edge", result_o, 16'h1111);

        // R5: both swaps on a move cancel
        drive({4'b0110, 4'b0011, 16'hBEEF, 16'h0000, 22'h0});
        @(negedge clk);
        check("R5 double swap", result_o, 16'hBEEF);

        // R1: reset in mid-run clears a nonzero result
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run result", result_o, '0);
        check("R1 mid-run wr/status", {10'h0, wr_o, lgt_o, agt_o, eq_o, cy_o, ov_o}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired got running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule